// File: doc/BRIEF.md
# Ethernet PHY Advertisement and Mode-Select Registers

This block is the management-register slice of a 10/100 Ethernet PHY that decides which link technology the port offers during auto-negotiation, or which one it forces when negotiation is off. The negotiation engine, link pulse logic, serial management decoder and analog front end all sit outside. They consume this block's resolved advertisement word, its negotiation enable, its restart pulse and its forced speed and duplex.

A configuration strap chooses between two modes. In pin-driven mode, further straps choose one single technology, the enable for negotiation and the forced speed and duplex. The ability bits of the advertisement register are then read-only. In management-driven mode, a simple register port sets all of this. The ability bits are writable there and come out of reset with every technology offered. A control word holds the negotiation enable, the forced speed, the forced duplex and a self-clearing restart request.

The block also returns a fixed status word. Its capability bits always list every technology the PHY supports, whatever is being advertised.

Top module: `phy_adv_regs`

## Requirements
- R1: After synchronous reset in management mode (`cfg_sw_mode`=1), `adv_word` is 16'h01E1, `an_enable`, `force_spd100` and `force_fdx` are 1, and `an_restart` is 0.
- R2: In pin mode (`cfg_sw_mode`=0), `adv_word[8:5]` is one-hot, chosen by `cfg_spd100` (1 = 100 Mb/s) and `cfg_fdx` (1 = full duplex). The mapping is bit 5 = 10 half, bit 6 = 10 full, bit 7 = 100 half, bit 8 = 100 full. All other bits above the selector are 0.
- R3: In pin mode, writes to register 4 do not change `adv_word` or the register-4 read data. The stored ability value is also left as it was, so it is visible again on return to management mode.
- R4: In pin mode, `an_enable` follows `cfg_an_sel`, `force_spd100` follows `cfg_spd100`, and `force_fdx` follows `cfg_fdx`.
- R5: In management mode, a write to register 4 updates ability bits 8:5 from write-data bits 8:5 on the next clock. The other write-data bits are ignored.
- R6: Bits 4:0 of `adv_word`, and of register 4 read data, are always 5'b00001.
- R7: Register 1 always reads 16'h7809. Bits 14:11 report 100 full, 100 half, 10 full and 10 half, bit 3 reports negotiation ability and bit 0 reports extended registers.
- R8: In management mode, control register 0 bit 12 drives `an_enable`, bit 13 drives `force_spd100` and bit 8 drives `force_fdx`. Register 0 read data shows the effective values of these three outputs at the same bit positions, in either mode.
- R9: In management mode, a write to register 0 with bit 9 set makes `an_restart` high for exactly the cycle after that write. Bit 9 always reads 0. In pin mode such a write produces no pulse.
- R10: Reads of any register address other than 0, 1 and 4 return 0.
- R11: A synchronous reset applied mid-operation restores the ability bits to 4'hF and the control bits to their defaults (speed 100, negotiation on, full duplex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sw_mode | input | 1 | Mode strap: 1 = management-driven, 0 = pin-driven |
| cfg_an_sel | input | 1 | Pin-mode negotiation enable strap |
| cfg_spd100 | input | 1 | Pin-mode speed strap, 1 = 100 Mb/s |
| cfg_fdx | input | 1 | Pin-mode duplex strap, 1 = full duplex |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register number |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational register read data |
| adv_word | output | 16 | Resolved advertisement word |
| an_enable | output | 1 | Auto-negotiation enable |
| an_restart | output | 1 | One-cycle negotiation restart pulse |
| force_spd100 | output | 1 | Forced speed, 1 = 100 Mb/s |
| force_fdx | output | 1 | Forced duplex, 1 = full |

## Verification
The assertions check several properties on every cycle:
- the one-hot ability pattern in pin mode;
- that the forced outputs track the straps in pin mode;
- the fixed selector and status words;
- zero reads from unused addresses;
- that every restart pulse is preceded by a qualifying control write;
- that the ability bits hold steady in management mode when no register-4 write occurs.

Only the bench scenarios can show the rest:
- the reset values;
- the exact encoding picked by each strap combination;
- that a pin-mode write leaves the stored ability value untouched for a later return to management mode;
- that a mid-run reset restores defaults.

The bench shows these with a cycle-level reference model.

// File: rtl/phy_adv_pkg.sv
package phy_adv_pkg;
  localparam int REG_AW = 5;
  localparam int REG_DW = 16;
  localparam int TAF_W  = 4;
  localparam int TAF_LO = 5;
  localparam int SEL_W  = 5;
  localparam int PAD_W  = REG_DW - TAF_W - SEL_W;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 5'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 5'd1;
  localparam logic [REG_AW-1:0] ADDR_ADV  = 5'd4;

  localparam int BIT_SPD     = 13;
  localparam int BIT_ANEN    = 12;
  localparam int BIT_RESTART = 9;
  localparam int BIT_FDX     = 8;

  localparam logic [SEL_W-1:0]  SELECTOR_STD = 5'b00001;
  localparam logic [REG_DW-1:0] STATUS_WORD  = 16'h7809;
  localparam logic [TAF_W-1:0]  TAF_DEFAULT  = {TAF_W{1'b1}};

  typedef struct packed {
    logic spd100;
    logic an_en;
    logic fdx;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{spd100: 1'b1, an_en: 1'b1, fdx: 1'b1};

  // One technology bit from speed and duplex: index = {speed, duplex}
  function automatic logic [TAF_W-1:0] tech_onehot(input logic spd100, input logic fdx);
    logic [TAF_W-1:0] v;
    v = '0;
    v[{spd100, fdx}] = 1'b1;
    return v;
  endfunction

  function automatic logic [REG_DW-1:0] pack_adv(input logic [TAF_W-1:0] taf);
    return {{PAD_W{1'b0}}, taf, SELECTOR_STD};
  endfunction

  function automatic logic [REG_DW-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_DW-1:0] w;
    w = '0;
    w[BIT_SPD]  = c.spd100;
    w[BIT_ANEN] = c.an_en;
    w[BIT_FDX]  = c.fdx;
    return w;
  endfunction
endpackage

// File: rtl/phy_adv_ctrl_reg.sv
module phy_adv_ctrl_reg
  import phy_adv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sw_mode,
  input  logic  ctrl_wr,
  input  logic  wr_spd,
  input  logic  wr_anen,
  input  logic  wr_restart,
  input  logic  wr_fdx,
  output ctrl_t ctrl_q,
  output logic  restart_req,
  output logic  restart_pulse
);
  assign restart_req = ctrl_wr && wr_restart && sw_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q        <= CTRL_DEFAULT;
      restart_pulse <= 1'b0;
    end else begin
      restart_pulse <= restart_req;
      if (ctrl_wr) begin
        ctrl_q.spd100 <= wr_spd;
        ctrl_q.an_en  <= wr_anen;
        ctrl_q.fdx    <= wr_fdx;
      end
    end
  end
endmodule

// File: rtl/phy_adv_taf_reg.sv
module phy_adv_taf_reg
  import phy_adv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_mode,
  input  logic             adv_wr,
  input  logic [TAF_W-1:0] wr_taf,
  output logic             taf_wr_hit,
  output logic [TAF_W-1:0] taf_q
);
  assign taf_wr_hit = adv_wr && sw_mode;

  always_ff @(posedge clk) begin
    if (rst)             taf_q <= TAF_DEFAULT;
    else if (taf_wr_hit) taf_q <= wr_taf;
  end
endmodule

// File: rtl/phy_adv_resolve.sv
module phy_adv_resolve
  import phy_adv_pkg::*;
(
  input  logic              sw_mode,
  input  logic              pin_an,
  input  logic              pin_spd,
  input  logic              pin_fdx,
  input  ctrl_t             ctrl_q,
  input  logic [TAF_W-1:0]  taf_q,
  output logic [REG_DW-1:0] adv_word,
  output ctrl_t             eff
);
  logic [TAF_W-1:0] pin_taf;

  assign pin_taf = tech_onehot(pin_spd, pin_fdx);

  always_comb begin
    if (sw_mode) begin
      adv_word = pack_adv(taf_q);
      eff      = ctrl_q;
    end else begin
      adv_word   = pack_adv(pin_taf);
      eff.spd100 = pin_spd;
      eff.an_en  = pin_an;
      eff.fdx    = pin_fdx;
    end
  end
endmodule

// File: rtl/phy_adv_regs.sv
module phy_adv_regs
  import phy_adv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_sw_mode,
  input  logic              cfg_an_sel,
  input  logic              cfg_spd100,
  input  logic              cfg_fdx,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [REG_DW-1:0] adv_word,
  output logic              an_enable,
  output logic              an_restart,
  output logic              force_spd100,
  output logic              force_fdx
);
  logic             ctrl_wr, adv_wr;
  logic             restart_req, taf_wr_hit;
  ctrl_t            ctrl_q, eff;
  logic [TAF_W-1:0] taf_q;
  logic             unused_wbits;

  assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
  assign adv_wr  = reg_we && (reg_addr == ADDR_ADV);
  assign unused_wbits = ^{reg_wdata[15:14], reg_wdata[11:10], reg_wdata[4:0]};

  phy_adv_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .sw_mode(cfg_sw_mode), .ctrl_wr(ctrl_wr),
    .wr_spd(reg_wdata[BIT_SPD]), .wr_anen(reg_wdata[BIT_ANEN]),
    .wr_restart(reg_wdata[BIT_RESTART]), .wr_fdx(reg_wdata[BIT_FDX]),
    .ctrl_q(ctrl_q), .restart_req(restart_req), .restart_pulse(an_restart)
  );

  phy_adv_taf_reg u_taf (
    .clk(clk), .rst(rst), .sw_mode(cfg_sw_mode), .adv_wr(adv_wr),
    .wr_taf(reg_wdata[TAF_LO +: TAF_W]), .taf_wr_hit(taf_wr_hit), .taf_q(taf_q)
  );

  phy_adv_resolve u_res (
    .sw_mode(cfg_sw_mode), .pin_an(cfg_an_sel), .pin_spd(cfg_spd100),
    .pin_fdx(cfg_fdx), .ctrl_q(ctrl_q), .taf_q(taf_q),
    .adv_word(adv_word), .eff(eff)
  );

  assign an_enable    = eff.an_en;
  assign force_spd100 = eff.spd100;
  assign force_fdx    = eff.fdx;

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = pack_ctrl(eff);
      ADDR_STAT: reg_rdata = STATUS_WORD;
      ADDR_ADV:  reg_rdata = adv_word;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/phy_adv_chk.sv
module phy_adv_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_sw_mode,
  input logic        cfg_an_sel,
  input logic        cfg_spd100,
  input logic        cfg_fdx,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic [15:0] adv_word,
  input logic        an_enable,
  input logic        an_restart,
  input logic        force_spd100,
  input logic        force_fdx,
  input logic        restart_req,
  input logic        taf_wr_hit
);
  p_pin_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_sw_mode |-> ($countones(adv_word[8:5]) == 1 && adv_word[15:9] == 7'd0));

  p_pin_force_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_sw_mode |-> (an_enable == cfg_an_sel && force_spd100 == cfg_spd100
                      && force_fdx == cfg_fdx));

  p_pin_no_taf_write_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_sw_mode |-> !taf_wr_hit);

  p_taf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_sw_mode && $past(cfg_sw_mode) && !$past(rst) && !$past(reg_we && reg_addr == 5'd4))
      |-> $stable(adv_word[8:5]));

  p_selector_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 5'd4) |-> (reg_rdata[4:0] == 5'b00001));

  p_status_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 5'd1) |-> (reg_rdata == 16'h7809));

  p_restart_cause_r9: assert property (@(posedge clk) disable iff (rst)
    an_restart |-> $past(reg_we && reg_addr == 5'd0 && reg_wdata[9] && cfg_sw_mode));

  p_restart_follow_r9: assert property (@(posedge clk) disable iff (rst)
    restart_req |=> an_restart);

  p_bit9_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 5'd0) |-> !reg_rdata[9]);

  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != 5'd0 && reg_addr != 5'd1 && reg_addr != 5'd4) |-> (reg_rdata == 16'd0));
endmodule

bind phy_adv_regs phy_adv_chk u_chk (
  .clk(clk), .rst(rst), .cfg_sw_mode(cfg_sw_mode), .cfg_an_sel(cfg_an_sel),
  .cfg_spd100(cfg_spd100), .cfg_fdx(cfg_fdx), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .adv_word(adv_word), .an_enable(an_enable), .an_restart(an_restart),
  .force_spd100(force_spd100), .force_fdx(force_fdx),
  .restart_req(restart_req), .taf_wr_hit(taf_wr_hit)
);

// File: tb/test_phy_adv_regs.sv
module test_phy_adv_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw = 1'b1, an_sel = 1'b0, spd = 1'b0, fdx = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = 5'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata, adv;
  logic        an_en, restart, fspd, ffdx;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    done = 0;

  // reference model state
  logic [3:0] m_taf;
  logic       m_spd, m_an, m_fdx, m_pulse;

  always #4 clk = ~clk;

  phy_adv_regs i_phy_adv_regs (
    .clk(clk), .rst(rst), .cfg_sw_mode(sw), .cfg_an_sel(an_sel),
    .cfg_spd100(spd), .cfg_fdx(fdx), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .adv_word(adv),
    .an_enable(an_en), .an_restart(restart), .force_spd100(fspd), .force_fdx(ffdx)
  );

  task automatic check(input string req, input string what, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_taf = 4'hF; m_spd = 1; m_an = 1; m_fdx = 1; m_pulse = 0;
    end else begin
      m_pulse = we && addr == 5'd0 && wdata[9] && sw;
      if (we && addr == 5'd0) begin
        m_spd = wdata[13]; m_an = wdata[12]; m_fdx = wdata[8];
      end
      if (we && addr == 5'd4 && sw) m_taf = wdata[8:5];
    end
  end

  function automatic logic [15:0] exp_adv();
    logic [3:0] t;
    if (sw) t = m_taf;
    else begin
      int idx;
      idx = spd * 2 + fdx;   // 10H=bit5, 10F=bit6, 100H=bit7, 100F=bit8
      t = 4'd0;
      t[idx] = 1'b1;
    end
    return {7'd0, t, 5'b00001};
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      logic e_an, e_spd, e_fdx;
      logic [15:0] e_rd;
      e_an  = sw ? m_an  : an_sel;
      e_spd = sw ? m_spd : spd;
      e_fdx = sw ? m_fdx : fdx;
      case (addr)
        5'd0:    e_rd = (16'(e_spd) << 13) | (16'(e_an) << 12) | (16'(e_fdx) << 8);
        5'd1:    e_rd = 16'h7809;
        5'd4:    e_rd = exp_adv();
        default: e_rd = 16'h0000;
      endcase
      check(cur_req, "adv_word", adv, exp_adv());
      check(cur_req, "an_enable", {15'd0, an_en}, {15'd0, e_an});
      check(cur_req, "force_spd100", {15'd0, fspd}, {15'd0, e_spd});
      check(cur_req, "force_fdx", {15'd0, ffdx}, {15'd0, e_fdx});
      check(cur_req, "an_restart", {15'd0, restart}, {15'd0, m_pulse});
      check(cur_req, "reg_rdata", rdata, e_rd);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(posedge clk); #2;
    addr = a;
    step(1);
  endtask

  initial begin
    // R1 / R11: reset state in management mode
    cur_req = "R1";
    step(3);
    rst = 1'b0;
    step(1);
    @(negedge clk);
    check("R1", "adv_word after reset", adv, 16'h01E1);
    rd(5'd0);

    cur_req = "R7";  rd(5'd1);
    cur_req = "R6";  rd(5'd4);
    cur_req = "R10"; rd(5'd2); rd(5'd3); rd(5'd5); rd(5'd31);

    // R5: management-mode writes to ability bits
    cur_req = "R5";
    wr(5'd4, 16'hFE1F);  // all ability bits zero, junk elsewhere
    rd(5'd4);
    @(negedge clk); check("R5", "taf after write", adv, 16'h0001);
    wr(5'd4, 16'h0040);
    rd(5'd4);
    wr(5'd4, 16'h01A0);
    step(2);

    // R8: control bits drive outputs
    cur_req = "R8";
    wr(5'd0, 16'h0100);  // neg off, 10 Mb/s, full duplex
    rd(5'd0);
    @(negedge clk); check("R8", "force_fdx", {15'd0, ffdx}, 16'd1);
    wr(5'd0, 16'h2000);
    rd(5'd0);

    // R9: restart pulse, back-to-back and single
    cur_req = "R9";
    wr(5'd0, 16'h3200);
    step(3);
    @(posedge clk); #2;
    we = 1'b1; addr = 5'd0; wdata = 16'h1200;
    step(1); step(1);
    we = 1'b0;
    step(3);

    // R2 / R4: pin mode, every strap combination
    sw = 1'b0;
    for (int k = 0; k < 8; k++) begin
      cur_req = (k < 4) ? "R2" : "R4";
      an_sel = k[2]; spd = k[1]; fdx = k[0];
      rd(5'd4);
      rd(5'd0);
    end
    an_sel = 1'b1; spd = 1'b1; fdx = 1'b0;
    step(1);
    @(negedge clk); check("R2", "100 half one-hot", adv, 16'h0081);

    // R3: pin-mode ability writes ignored; R9: no restart in pin mode
    cur_req = "R3";
    wr(5'd4, 16'h01E0);
    rd(5'd4);
    cur_req = "R9";
    wr(5'd0, 16'h3300);
    @(negedge clk); check("R9", "no pulse in pin mode", {15'd0, restart}, 16'd0);
    step(2);

    // back to management: stored ability value preserved (R3)
    cur_req = "R3";
    sw = 1'b1;
    rd(5'd4);
    @(negedge clk); check("R3", "stored taf kept", adv, 16'h01A1);

    // R11: reset mid-operation
    cur_req = "R11";
    wr(5'd4, 16'h0020);
    wr(5'd0, 16'h0000);
    @(posedge clk); #2; rst = 1'b1;
    step(2);
    rst = 1'b0;
    rd(5'd0);
    @(negedge clk); check("R11", "adv after reset", adv, 16'h01E1);
    rd(5'd4);
    step(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule